// File: doc/BRIEF.md
# Opcode-to-Microcode Dispatch Mapper

This block turns the opcode fields of the current instruction into a 12-bit microprogram start address by means of a lookup table held inside the block as a computed case ROM. Each instruction falls into one of three classes. Direct instructions go straight to their own routine. Memory-reference instructions go first to a shared effective-address routine. Special-operation instructions go first to a shared preparation routine.

A two-step instruction reaches its own execute routine through a second, look-up dispatch. The sequencer raises a look-up jump strobe when the shared routine ends. The instruction fields held in the block do not change between the two dispatches. A one-bit phase flag forms the top bit of the table index, and that flag alone turns the second lookup into a different entry, so the same opcode does not send the sequencer back into the shared routine forever.

The output is a plain strobe with no back-pressure. `uaddr_valid` is high for exactly one cycle per dispatch, and the consumer must take `uaddr` in that cycle. A new instruction load always has priority over a look-up jump.

Top module: `dm_dispatch_mapper`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `uaddr_valid` is 0 and `uaddr` is 0. After reset no second dispatch is pending.
- R2: The major field is `op_fields[7:4]` and the minor field is `op_fields[3:0]`. When `ir_load` is high with major 1..3, or with major 0 and minor 0, the next cycle shows `uaddr_valid`=1 and `uaddr` = 0x100 + `op_fields`. No second dispatch is then pending.
- R3: When `ir_load` is high with major 4..15, the next cycle shows `uaddr` = 0x040, the shared effective-address routine. A second dispatch is then pending.
- R4: When `ir_load` is high with major 0 and minor 1..15, the next cycle shows `uaddr` = 0x050, the shared special-operation routine. A second dispatch is then pending.
- R5: A `lookup_jump` while a memory-reference dispatch is pending, with `ind_req`=0 or `ind_resolved`=1, gives `uaddr` = 0x400 + 16×major in the next cycle and clears the pending state.
- R6: The same look-up for a pending special operation gives `uaddr` = 0x600 + 8×minor in the next cycle and clears the pending state.
- R7: A `lookup_jump` while a dispatch is pending, with `ind_req`=1 and `ind_resolved`=0, gives the shared routine address again (0x040 or 0x050) in the next cycle. The dispatch stays pending.
- R8: A `lookup_jump` with no dispatch pending is ignored: `uaddr_valid` stays 0 in the next cycle.
- R9: `uaddr_valid` is high only in the cycle after an accepted `ir_load` or an accepted `lookup_jump`, and only for that one cycle.
- R10: When `ir_load` and `lookup_jump` are high in the same cycle, the load wins. The dispatch is the first-step address of the new fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_load | input | 1 | A new instruction's fields are present this cycle |
| op_fields | input | 8 | Major field in [7:4], minor field in [3:0] |
| lookup_jump | input | 1 | The shared routine asks for the look-up re-dispatch |
| ind_req | input | 1 | The instruction asks for indirect addressing |
| ind_resolved | input | 1 | One level of indirection has been resolved |
| uaddr | output | 12 | Microprogram start address |
| uaddr_valid | output | 1 | One-cycle strobe marking a dispatch |

## Verification
Most internal faults show up at the ports within one look-up jump. A phase flag stuck at 0 makes the look-up jump silent, so `uaddr_valid` stays low. A phase flag that fails to clear makes a later look-up jump produce a second execute address. A corrupted held field gives a wrong execute address on the look-up that follows the next load. A wrong class decode is visible in the very next cycle, as a first-step address from the wrong table region.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int DM_FLD_W    = 4;
  localparam int DM_MEMREF_LO = 4;

  typedef enum logic [1:0] {
    CLS_DIRECT  = 2'd0,
    CLS_MEMREF  = 2'd1,
    CLS_SPECIAL = 2'd2
  } op_class_t;

  function automatic op_class_t classify(input logic [DM_FLD_W-1:0] maj,
                                         input logic [DM_FLD_W-1:0] mn);
    if (maj >= DM_FLD_W'(DM_MEMREF_LO)) return CLS_MEMREF;
    if (maj == '0 && mn != '0)          return CLS_SPECIAL;
    return CLS_DIRECT;
  endfunction
endpackage

// File: rtl/dm_decode.sv
module dm_decode
  import dm_pkg::*;
#(
  parameter int FLD_W = DM_FLD_W
) (
  input  logic [2*FLD_W-1:0] fields,
  output logic [FLD_W-1:0]   maj,
  output logic [FLD_W-1:0]   mn,
  output logic               two_step
);
  op_class_t cls;
  always_comb begin
    maj      = fields[2*FLD_W-1:FLD_W];
    mn       = fields[FLD_W-1:0];
    cls      = classify(maj, mn);
    two_step = (cls != CLS_DIRECT);
  end
endmodule

// File: rtl/dm_phase.sv
module dm_phase #(
  parameter int FLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_two_step,
  input  logic [FLD_W-1:0] load_maj,
  input  logic [FLD_W-1:0] load_mn,
  input  logic             lookup,
  input  logic             exec_fire,
  input  logic             retry,
  output logic             phase,
  output logic [FLD_W-1:0] held_maj,
  output logic [FLD_W-1:0] held_mn
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      held_maj <= '0;
      held_mn  <= '0;
    end else if (load) begin
      phase    <= load_two_step;
      held_maj <= load_maj;
      held_mn  <= load_mn;
    end else if (exec_fire) begin
      phase    <= 1'b0;
    end
  end

  AST_LOAD_ARMS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (phase == $past(load_two_step))); // R3
  AST_PHASE_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase) |-> ($past(exec_fire) || $past(load))); // R5
  AST_RETRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (retry && !load) |=> phase); // R7
  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && lookup) |=> ($stable(held_maj) && $stable(held_mn))); // R7
endmodule

// File: rtl/dm_rom.sv
module dm_rom
  import dm_pkg::*;
#(
  parameter int          FLD_W       = DM_FLD_W,
  parameter int          UA_W        = 12,
  parameter logic [11:0] EA_ADDR     = 12'h040,
  parameter logic [11:0] SPC_ADDR    = 12'h050,
  parameter logic [11:0] DIRECT_BASE = 12'h100,
  parameter logic [11:0] EXEC_BASE   = 12'h400,
  parameter logic [11:0] SPEXEC_BASE = 12'h600,
  parameter int          SPEXEC_SH   = 3
) (
  input  logic [2*FLD_W:0] idx,
  output logic [UA_W-1:0]  entry
);
  localparam int IDX_W = 2*FLD_W + 1;

  logic             ph;
  logic [FLD_W-1:0] maj;
  logic [FLD_W-1:0] mn;
  op_class_t        cls;

  always_comb begin
    ph  = idx[IDX_W-1];
    maj = idx[2*FLD_W-1:FLD_W];
    mn  = idx[FLD_W-1:0];
    cls = classify(maj, mn);
    unique case ({ph, cls})
      {1'b0, CLS_MEMREF}:  entry = UA_W'(EA_ADDR);
      {1'b0, CLS_SPECIAL}: entry = UA_W'(SPC_ADDR);
      {1'b1, CLS_MEMREF}:  entry = UA_W'(EXEC_BASE) + (UA_W'(maj) << FLD_W);
      {1'b1, CLS_SPECIAL}: entry = UA_W'(SPEXEC_BASE) + (UA_W'(mn) << SPEXEC_SH);
      default:             entry = UA_W'(DIRECT_BASE) + UA_W'({maj, mn});
    endcase
  end
endmodule

// File: rtl/dm_dispatch_mapper.sv
module dm_dispatch_mapper
  import dm_pkg::*;
#(
  parameter int FLD_W = DM_FLD_W,
  parameter int UA_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_load,
  input  logic [2*FLD_W-1:0] op_fields,
  input  logic              lookup_jump,
  input  logic              ind_req,
  input  logic              ind_resolved,
  output logic [UA_W-1:0]   uaddr,
  output logic              uaddr_valid
);
  localparam int IDX_W = 2*FLD_W + 1;

  logic [FLD_W-1:0] dec_maj, dec_mn, held_maj, held_mn;
  logic             dec_two_step, phase;
  logic             take_lj, exec_fire, retry, fire;
  logic [IDX_W-1:0] rom_idx;
  logic [UA_W-1:0]  rom_entry;

  dm_decode #(.FLD_W(FLD_W)) u_decode (
    .fields(op_fields), .maj(dec_maj), .mn(dec_mn), .two_step(dec_two_step)
  );

  always_comb begin
    take_lj   = lookup_jump && !ir_load && phase;
    exec_fire = take_lj && (!ind_req || ind_resolved);
    retry     = take_lj && ind_req && !ind_resolved;
    fire      = ir_load || take_lj;
    rom_idx   = ir_load ? {1'b0, dec_maj, dec_mn}
                        : {exec_fire, held_maj, held_mn};
  end

  dm_phase #(.FLD_W(FLD_W)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .load(ir_load), .load_two_step(dec_two_step),
    .load_maj(dec_maj), .load_mn(dec_mn),
    .lookup(lookup_jump), .exec_fire(exec_fire), .retry(retry),
    .phase(phase), .held_maj(held_maj), .held_mn(held_mn)
  );

  dm_rom #(.FLD_W(FLD_W), .UA_W(UA_W)) u_rom (
    .idx(rom_idx), .entry(rom_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uaddr_valid <= 1'b0;
      uaddr       <= '0;
    end else begin
      uaddr_valid <= fire;
      if (fire) uaddr <= rom_entry;
    end
  end

  AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    uaddr_valid |-> $past(ir_load || lookup_jump)); // R9
  AST_IDLE_LOOKUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_jump && !ir_load && !phase) |=> !uaddr_valid); // R8
  AST_EXEC_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |=> (uaddr_valid && uaddr[UA_W-1:UA_W-2] != 2'b00)); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_load && lookup_jump) |=> (uaddr_valid && uaddr[UA_W-1:UA_W-2] == 2'b00)); // R10
endmodule

// File: tb/test_dm_dispatch_mapper.sv
module test_dm_dispatch_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ir_load, lookup_jump, ind_req, ind_resolved;
  logic [7:0]  op_fields;
  logic [11:0] uaddr;
  logic        uaddr_valid;

  int checks = 0, failures = 0, cycles = 0;
  logic        m_phase;
  logic [7:0]  m_f;
  logic        exp_valid;
  logic [11:0] exp_uaddr;
  string       exp_tag;

  always #2 clk = ~clk;

  dm_dispatch_mapper i_dm_dispatch_mapper (
    .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .op_fields(op_fields),
    .lookup_jump(lookup_jump), .ind_req(ind_req), .ind_resolved(ind_resolved),
    .uaddr(uaddr), .uaddr_valid(uaddr_valid)
  );

  function automatic int cls_of(input logic [7:0] f);
    if (f[7:4] >= 4) return 1;
    if (f[7:4] == 0 && f[3:0] != 0) return 2;
    return 0;
  endfunction

  function automatic logic [11:0] first_addr(input logic [7:0] f);
    case (cls_of(f))
      1: return 12'h040;
      2: return 12'h050;
      default: return 12'h100 + 12'(f);
    endcase
  endfunction

  function automatic logic [11:0] exec_addr(input logic [7:0] f);
    if (cls_of(f) == 1) return 12'h400 + 12'(f[7:4]) * 12'd16;
    return 12'h600 + 12'(f[3:0]) * 12'd8;
  endfunction

  task automatic check(input logic v, input logic [11:0] a, input string tag);
    checks++;
    if (uaddr_valid !== v || (v && uaddr !== a)) begin
      failures++;
      $display("FAIL %s: actual valid=%0b uaddr=%h expected valid=%0b uaddr=%h",
               tag, uaddr_valid, uaddr, v, a);
    end
  endtask

  task automatic step(input logic ld, input logic [7:0] f, input logic lj,
                      input logic ir, input logic rs);
    ir_load = ld; op_fields = f; lookup_jump = lj; ind_req = ir; ind_resolved = rs;
    exp_valid = 1'b0;
    if (ld) begin
      exp_valid = 1'b1; exp_uaddr = first_addr(f);
      m_phase = (cls_of(f) != 0); m_f = f;
      exp_tag = lj ? "R10" : (cls_of(f) == 1 ? "R3" : (cls_of(f) == 2 ? "R4" : "R2"));
    end else if (lj && m_phase) begin
      exp_valid = 1'b1;
      if (ir && !rs) begin
        exp_uaddr = first_addr(m_f); exp_tag = "R7";
      end else begin
        exp_uaddr = exec_addr(m_f); m_phase = 1'b0;
        exp_tag = (cls_of(m_f) == 1) ? "R5" : "R6";
      end
    end else begin
      exp_tag = lj ? "R8" : "R9";
    end
    @(negedge clk);
    check(exp_valid, exp_uaddr, exp_tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1D5EED));
    rst_n = 1'b0; ir_load = 0; lookup_jump = 0; ind_req = 0; ind_resolved = 0;
    op_fields = 8'h00; m_phase = 0; m_f = 0; exp_uaddr = 0;
    repeat (3) @(negedge clk);
    check(1'b0, 12'h000, "R1");
    if (uaddr !== 12'h000) begin
      failures++; $display("FAIL R1: actual uaddr=%h expected 000", uaddr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 12'h000, "R1");
    step(0, 8'h00, 1, 0, 0);                 // R1 R8: nothing pending after reset

    for (int mj = 0; mj < 16; mj++) begin    // every major, two-step and single
      step(1, 8'((mj << 4) | 5), 0, 0, 0);
      step(0, 8'h00, 0, 0, 0);               // R9: single-cycle strobe
      step(0, 8'h00, 1, 0, 0);               // R5/R6 or R8
      step(0, 8'h00, 1, 0, 0);               // R8: no repeat dispatch
    end
    step(1, 8'h00, 0, 0, 0);                 // R2: major 0 minor 0 is direct
    step(0, 8'h00, 1, 0, 0);                 // R8
    step(1, 8'h0F, 0, 0, 0);                 // R4
    step(0, 8'h00, 1, 1, 0);                 // R7 retry
    step(0, 8'h00, 1, 1, 0);                 // R7 retry again
    step(0, 8'h00, 1, 1, 1);                 // R6 after resolution
    step(1, 8'hA3, 0, 0, 0);                 // R3
    step(1, 8'h27, 1, 0, 0);                 // R10 load wins over look-up
    step(0, 8'h00, 1, 0, 0);                 // R8: new direct fields
    step(1, 8'hC1, 1, 0, 0);                 // R10 with two-step
    step(0, 8'h00, 1, 0, 0);                 // R5

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] f;
      f = 8'($urandom);
      if ($urandom % 4 == 0) f[7:4] = 4'h0;
      step(($urandom % 10) < 3, f, ($urandom % 10) < 5,
           ($urandom % 2) == 1, ($urandom % 3) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule